// File: doc/BRIEF.md
# SPI Target with Shared-Pointer Ring Buffers

This block is an SPI target for clock mode 0. It samples the controller's data on rising SCLK edges and drives its own data on falling edges. Each received byte goes into an input ring. The byte sent at the same time comes from an output ring. One byte pointer indexes both rings, so the byte sent at position N and the byte received at position N share a slot index. When the pointer passes the last slot it wraps to slot 0.

Firmware on the local bus side refills the rings in halves. An event fires when the pointer reaches the middle of the ring and another fires when it wraps, so software can refill one half while the other half is in use. Three more events help with framing: one on chip-select assertion, one on chip-select release, and a fill-level event. The fill-level event fires after a programmable number of bytes in a transaction, which is useful to take in a fixed-size header. Every event is a sticky flag that is cleared by writing 1. Each flag can be routed to a single interrupt line.

SCLK, chip-select and MOSI are resynchronised into the system clock through two flops. The local bus accepts a write or a read request in every cycle and never stalls, so it has no back-pressure. Read data appears on `bus_rdata` one cycle after `bus_rd`. A register index uses the low three address bits while the top address bit is 0. With the top address bit at 1, the low bits give a ring slot: reads return the input ring and writes go to the output ring.

Top module: `spi_ring_target`

## Requirements
- R1: After reset the block is disabled. Register 0 (control, bit 0 = enable) reads 0. Register 1 (level) reads 8. Register 2 (flags) reads 0. Register 4 (pointer) reads 0. Register 5 (status, bit 0 = busy) reads 0. `irq` is low.
- R2: Each byte is received MSB first, with MOSI sampled on rising SCLK edges while selected. The byte is stored in the input ring at the current pointer and read back at bus address DEPTH+slot.
- R3: While selected, MISO carries the output-ring byte at the current pointer, MSB first. The first bit is valid once chip-select is asserted. Each following bit is driven after a falling SCLK edge. Bus writes to address DEPTH+slot fill the output ring.
- R4: The pointer advances by one after every eighth bit and wraps from DEPTH-1 to 0. It keeps its value across transactions. The bits of a partial byte left when chip-select is released are discarded.
- R5: Flag bit 2 (half) is set when the pointer moves from DEPTH/2-1 to DEPTH/2. Flag bit 3 (full) is set when the pointer wraps to 0.
- R6: Flag bit 4 (level) is set when the byte count since the last chip-select assertion equals the threshold in level register bits 6:0. Writing level bit 7 disables the event and zeroes the threshold, so the register then reads 0x80.
- R7: Flag bit 0 is set on chip-select assertion and flag bit 1 on chip-select release. Flag bit 1 is set even when no SCLK edge occurred during the select.
- R8: The status busy bit reads 1 exactly while chip-select is asserted.
- R9: Writing 1 to a bit of register 2 clears that flag. Writing 0 leaves it unchanged.
- R10: `irq` is the OR of each flag ANDed with the matching bit of register 3 (interrupt enable).
- R11: Clearing the enable bit clears all flags and sets the pointer to 0. While disabled, SPI traffic changes no flag, ring slot or pointer, and `spi_miso_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI clock, mode 0 |
| spi_csn | input | 1 | Chip-select, active low |
| spi_mosi | input | 1 | Data from controller |
| spi_miso | output | 1 | Data to controller |
| spi_miso_oe | output | 1 | Output enable for MISO |
| bus_wr | input | 1 | Local bus write strobe |
| bus_rd | input | 1 | Local bus read strobe |
| bus_addr | input | $clog2(DEPTH)+1 | Register index or ring slot |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach from the ports occur within a single transaction. The ring must be driven far enough that the half mark, the wrap and the fill-level count all occur, and each must be observed at the byte where it should first appear. The stimulus runs one long select across the whole ring and reads the flags between bytes while SCLK is idle. A chip-select pulse with no SCLK edges and a select released after four bits are also generated, to show that the release flag is set and the partial byte is dropped.

// File: rtl/spit_pkg.sv
package spit_pkg;
  localparam int BYTE_W = 8;
  localparam int THR_W  = 7;
  localparam int NFLAG  = 5;

  localparam int FL_CSF  = 0;
  localparam int FL_CSR  = 1;
  localparam int FL_HALF = 2;
  localparam int FL_FULL = 3;
  localparam int FL_LVL  = 4;

  typedef enum logic [2:0] {
    RG_CTRL  = 3'd0,
    RG_LEVEL = 3'd1,
    RG_FLAGS = 3'd2,
    RG_IRQEN = 3'd3,
    RG_PTR   = 3'd4,
    RG_STAT  = 3'd5
  } reg_sel_e;

  // packed MSB first: bit 4 level .. bit 0 select-assert
  typedef struct packed {
    logic lvl;
    logic full;
    logic half;
    logic cs_rise;
    logic cs_fall;
  } evt_t;
endpackage

// File: rtl/spit_sync.sv
module spit_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta   <= RST_VAL;
      q_sync <= RST_VAL;
    end else begin
      meta   <= d_async;
      q_sync <= meta;
    end
  end
endmodule

// File: rtl/spit_engine.sv
module spit_engine
  import spit_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sclk_s,
  input  logic              csn_s,
  input  logic              mosi_s,
  input  logic [THR_W-1:0]  lvl_thr,
  input  logic              lvl_on,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic [PTR_W-1:0]  ptr,
  output logic              busy,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output evt_t              evt,
  output logic              miso,
  output logic              miso_oe
);
  logic             sclk_d, csn_d;
  logic [2:0]       bitcnt;
  logic [6:0]       shreg;
  logic [CNT_W-1:0] rxcnt, rx_next;
  logic             miso_q;
  logic             sel, sclk_rise, sclk_fall, cs_fall_p, cs_rise_p, byte_done;

  assign sel       = en & ~csn_s;
  assign sclk_rise = sel & sclk_s & ~sclk_d;
  assign sclk_fall = sel & ~sclk_s & sclk_d;
  assign cs_fall_p = en & csn_d & ~csn_s;
  assign cs_rise_p = en & ~csn_d & csn_s;
  assign byte_done = sclk_rise & ~cs_fall_p & (bitcnt == 3'd7);
  assign rx_next   = (rxcnt == '1) ? rxcnt : rxcnt + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
      ptr    <= '0;
      bitcnt <= '0;
      shreg  <= '0;
      rxcnt  <= '0;
      miso_q <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      csn_d  <= csn_s;
      if (!en) begin
        ptr    <= '0;
        bitcnt <= '0;
        shreg  <= '0;
        rxcnt  <= '0;
        miso_q <= 1'b0;
      end else if (cs_fall_p) begin
        bitcnt <= '0;
        rxcnt  <= '0;
        miso_q <= tx_byte[BYTE_W-1];
      end else begin
        if (sclk_rise) begin
          shreg  <= {shreg[5:0], mosi_s};
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) begin
            ptr   <= ptr + PTR_W'(1);
            rxcnt <= rx_next;
          end
        end
        if (sclk_fall) miso_q <= tx_byte[3'd7 - bitcnt];
      end
    end
  end

  assign wr_en       = byte_done;
  assign wr_data     = {shreg, mosi_s};
  assign evt.cs_fall = cs_fall_p;
  assign evt.cs_rise = cs_rise_p;
  assign evt.half    = byte_done & (ptr == PTR_W'(DEPTH/2 - 1));
  assign evt.full    = byte_done & (ptr == PTR_W'(DEPTH - 1));
  assign evt.lvl     = byte_done & lvl_on & (lvl_thr != '0) &
                       (rx_next == CNT_W'(lvl_thr));
  assign busy        = ~csn_s;
  assign miso        = miso_q;
  assign miso_oe     = sel;
endmodule

// File: rtl/spit_regs.sv
module spit_regs
  import spit_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int LVL_DEF = 8,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int ADDR_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              en,
  output logic [THR_W-1:0]  lvl_thr,
  output logic              lvl_on,
  input  logic [PTR_W-1:0]  ptr,
  input  logic              busy,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] tx_byte,
  input  evt_t              evt,
  output logic [NFLAG-1:0]  flags,
  output logic [NFLAG-1:0]  irq_en
);
  logic [BYTE_W-1:0] ibuf [DEPTH];
  logic [BYTE_W-1:0] obuf [DEPTH];
  logic              lvl_dis;
  logic              buf_hit;
  logic [PTR_W-1:0]  idx;
  reg_sel_e          rsel;
  logic [NFLAG-1:0]  clr_mask, evt_bits;

  assign buf_hit  = bus_addr[ADDR_W-1];
  assign idx      = bus_addr[PTR_W-1:0];
  assign rsel     = reg_sel_e'(bus_addr[2:0]);
  assign evt_bits = evt;
  assign clr_mask = (bus_wr && !buf_hit && rsel == RG_FLAGS) ? bus_wdata[NFLAG-1:0] : '0;
  assign lvl_on   = ~lvl_dis;
  assign tx_byte  = obuf[ptr];

  // control registers and flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      lvl_dis <= 1'b0;
      lvl_thr <= THR_W'(LVL_DEF);
      irq_en  <= '0;
      flags   <= '0;
    end else begin
      if (bus_wr && !buf_hit) begin
        case (rsel)
          RG_CTRL:  en <= bus_wdata[0];
          RG_LEVEL: begin
            lvl_dis <= bus_wdata[BYTE_W-1];
            lvl_thr <= bus_wdata[BYTE_W-1] ? '0 : bus_wdata[THR_W-1:0];
          end
          RG_IRQEN: irq_en <= bus_wdata[NFLAG-1:0];
          default:  ;
        endcase
      end
      if (!en) flags <= '0;
      else     flags <= (flags & ~clr_mask) | evt_bits;
    end
  end

  // ring storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        ibuf[i] <= '0;
        obuf[i] <= '0;
      end
    end else begin
      if (wr_en) ibuf[ptr] <= wr_data;
      if (bus_wr && buf_hit) obuf[idx] <= bus_wdata;
    end
  end

  // registered read port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (buf_hit) begin
        bus_rdata <= ibuf[idx];
      end else begin
        case (rsel)
          RG_CTRL:  bus_rdata <= {7'b0, en};
          RG_LEVEL: bus_rdata <= {lvl_dis, lvl_thr};
          RG_FLAGS: bus_rdata <= BYTE_W'(flags);
          RG_IRQEN: bus_rdata <= BYTE_W'(irq_en);
          RG_PTR:   bus_rdata <= BYTE_W'(ptr);
          RG_STAT:  bus_rdata <= {7'b0, busy};
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_ring_target.sv
module spi_ring_target
  import spit_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int LVL_DEF = 8,
  parameter int CNT_W   = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   spi_sclk,
  input  logic                   spi_csn,
  input  logic                   spi_mosi,
  output logic                   spi_miso,
  output logic                   spi_miso_oe,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [$clog2(DEPTH):0] bus_addr,
  input  logic [7:0]             bus_wdata,
  output logic [7:0]             bus_rdata,
  output logic                   irq
);
  localparam int PTR_W = $clog2(DEPTH);

  if ((1 << PTR_W) != DEPTH || DEPTH < 8 || DEPTH > 128) begin : g_bad_depth
    $error("DEPTH must be a power of two from 8 to 128");
  end

  logic              sclk_s, csn_s, mosi_s;
  logic              en_q, lvl_on, busy, wr_en;
  logic [THR_W-1:0]  lvl_thr;
  logic [PTR_W-1:0]  ptr;
  logic [BYTE_W-1:0] wr_data, tx_byte;
  logic [NFLAG-1:0]  flags, irq_en;
  evt_t              evt;

  spit_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({spi_sclk, spi_csn, spi_mosi}),
    .q_sync({sclk_s, csn_s, mosi_s})
  );

  spit_engine #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .en(en_q),
    .sclk_s(sclk_s), .csn_s(csn_s), .mosi_s(mosi_s),
    .lvl_thr(lvl_thr), .lvl_on(lvl_on), .tx_byte(tx_byte),
    .ptr(ptr), .busy(busy), .wr_en(wr_en), .wr_data(wr_data),
    .evt(evt), .miso(spi_miso), .miso_oe(spi_miso_oe)
  );

  spit_regs #(.DEPTH(DEPTH), .LVL_DEF(LVL_DEF)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .en(en_q), .lvl_thr(lvl_thr), .lvl_on(lvl_on),
    .ptr(ptr), .busy(busy), .wr_en(wr_en), .wr_data(wr_data),
    .tx_byte(tx_byte), .evt(evt), .flags(flags), .irq_en(irq_en)
  );

  assign irq = |(flags & irq_en);
endmodule

// File: rtl/spit_checker.sv
module spit_checker
  import spit_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [PTR_W-1:0] ptr,
  input logic [NFLAG-1:0] flags,
  input logic             busy,
  input logic             irq
);
  assert_disable_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (flags == '0 && ptr == '0));

  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr)) |-> (ptr == $past(ptr) + PTR_W'(1) || ptr == '0));

  assert_half_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[FL_HALF]) |-> ptr == PTR_W'(DEPTH/2));

  assert_wrap_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[FL_FULL]) |-> ptr == '0);

  assert_cs_assert_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && en) |=> flags[FL_CSF]);

  assert_cs_release_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && en) |=> flags[FL_CSR]);

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flags != '0);
endmodule

bind spi_ring_target spit_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_q), .ptr(ptr),
  .flags(flags), .busy(busy), .irq(irq)
);

// File: tb/sim_spi_ring_target.sv
module sim_spi_ring_target;
  localparam int CLK_P = 10;
  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic miso, miso_oe, irq;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] m_ibuf [DEPTH];
  logic [7:0] m_obuf [DEPTH];
  int exp_ptr = 0;

  always #(CLK_P/2) clk = ~clk;

  spi_ring_target #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [7:0] pat(int k);
    return 8'((k * 37 + 11) ^ (k >> 2));
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(int a, int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(int a, output int d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = int'(bus_rdata);
  endtask

  task automatic rd_check(string req, int a, int exp);
    int v;
    bus_read(a, v);
    check(req, v, exp);
  endtask

  task automatic cs_low;
    csn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_high;
    repeat (4) @(negedge clk);
    csn = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic spi_bits(int n, logic [7:0] tx, output logic [7:0] rx);
    rx = '0;
    for (int b = 7; b > 7 - n; b--) begin
      mosi = tx[b];
      repeat (4) @(negedge clk);
      rx[b] = miso;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  // full byte while enabled: updates model and checks MISO (R3)
  task automatic xfer(logic [7:0] tx);
    logic [7:0] rx;
    spi_bits(8, tx, rx);
    check("R3 miso byte", int'(rx), int'(m_obuf[exp_ptr]));
    m_ibuf[exp_ptr] = tx;
    exp_ptr = (exp_ptr + 1) % DEPTH;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int v;
    logic [7:0] junk;
    for (int i = 0; i < DEPTH; i++) begin
      m_ibuf[i] = '0;
      m_obuf[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd_check("R1 ctrl", 0, 0);
    rd_check("R1 level", 1, 8);
    rd_check("R1 flags", 2, 0);
    rd_check("R1 ptr", 4, 0);
    rd_check("R1 busy", 5, 0);
    check("R1 irq", int'(irq), 0);

    // enable, fill output ring
    bus_write(0, 1);
    for (int i = 0; i < DEPTH; i++) begin
      m_obuf[i] = 8'(i * 7 + 3);
      bus_write(DEPTH + i, m_obuf[i]);
    end

    // transaction A: three bytes
    cs_low();
    rd_check("R7 cs assert flag", 2, 1);
    rd_check("R8 busy high", 5, 1);
    for (int k = 0; k < 3; k++) xfer(pat(k));
    cs_high();
    rd_check("R7 cs release flag", 2, 3);
    rd_check("R8 busy low", 5, 0);
    rd_check("R4 ptr after 3", 4, 3);
    for (int i = 0; i < 3; i++) rd_check("R2 rx byte", DEPTH + i, m_ibuf[i]);

    // R9 write-one-to-clear
    bus_write(2, 32'h02);
    rd_check("R9 partial clear", 2, 1);
    bus_write(2, 32'h1F);
    rd_check("R9 clear all", 2, 0);

    // transaction B: rest of the ring, half mark, wrap, level at 8th byte
    cs_low();
    for (int k = 3; k < DEPTH; k++) begin
      xfer(pat(k));
      if (k == 9)  begin bus_read(2, v); check("R6 level not yet", (v >> 4) & 1, 0); end
      if (k == 10) begin bus_read(2, v); check("R6 level at 8th", (v >> 4) & 1, 1); end
      if (exp_ptr == DEPTH/2 - 1) begin bus_read(2, v); check("R5 half not yet", (v >> 2) & 1, 0); end
      if (exp_ptr == DEPTH/2)     begin bus_read(2, v); check("R5 half set", (v >> 2) & 1, 1); end
      if (exp_ptr == DEPTH - 1)   begin bus_read(2, v); check("R5 full not yet", (v >> 3) & 1, 0); end
    end
    cs_high();
    rd_check("R5 flags after wrap", 2, 32'h1F);
    rd_check("R4 ptr wrapped", 4, 0);
    for (int i = 0; i < DEPTH; i++) rd_check("R2 ring sweep", DEPTH + i, m_ibuf[i]);
    bus_write(2, 32'h1F);

    // R4 partial byte discarded
    cs_low();
    spi_bits(4, 8'hF0, junk);
    cs_high();
    rd_check("R4 ptr after partial", 4, 0);
    cs_low();
    xfer(8'h6C);
    cs_high();
    rd_check("R4 byte realigned", DEPTH + 0, 32'h6C);
    rd_check("R4 ptr after realign", 4, 1);

    // R6 level disabled then reprogrammed
    bus_write(1, 32'h85);
    rd_check("R6 disabled readback", 1, 32'h80);
    bus_write(2, 32'h1F);
    cs_low();
    for (int k = 0; k < 9; k++) xfer(pat(k + 100));
    cs_high();
    rd_check("R6 no level when disabled", 2, 3);
    bus_write(1, 3);
    rd_check("R6 threshold readback", 1, 3);
    bus_write(2, 32'h1F);
    cs_low(); xfer(pat(200)); xfer(pat(201)); cs_high();
    rd_check("R6 below threshold", 2, 3);
    bus_write(2, 32'h1F);
    cs_low(); xfer(pat(202)); xfer(pat(203)); xfer(pat(204)); cs_high();
    rd_check("R6 at threshold", 2, 32'h13);
    rd_check("R4 ptr running", 4, exp_ptr);

    // R7 release with no SCLK
    bus_write(2, 32'h1F);
    csn = 1'b0;
    repeat (6) @(negedge clk);
    csn = 1'b1;
    repeat (6) @(negedge clk);
    rd_check("R7 release without clocks", 2, 3);

    // R10 interrupt masking
    bus_write(3, 32'h04);
    check("R10 irq masked", int'(irq), 0);
    bus_write(3, 32'h02);
    check("R10 irq enabled", int'(irq), 1);
    bus_write(2, 32'h1F);
    check("R10 irq after clear", int'(irq), 0);

    // R11 disable
    bus_write(2, 32'h00);
    cs_low(); xfer(pat(300)); cs_high();
    bus_write(0, 0);
    rd_check("R11 flags cleared", 2, 0);
    rd_check("R11 ptr cleared", 4, 0);
    exp_ptr = 0;
    cs_low();
    check("R11 miso_oe low", int'(miso_oe), 0);
    spi_bits(8, 8'hA5, junk);
    cs_high();
    rd_check("R11 ptr unchanged", 4, 0);
    rd_check("R11 flags unchanged", 2, 0);
    rd_check("R11 ring unchanged", DEPTH + 0, m_ibuf[0]);
    check("R11 irq low", int'(irq), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule